// File: doc/BRIEF.md
# Sector-mapped cache controller

This block is a read/write cache controller whose storage and the backing memory are both cut into sectors of a fixed number of blocks. Every sector frame in the cache holds one sector tag. All tags are compared against the incoming address at the same time. Within the matching frame, the block bits of the address pick the block frame directly. Each block frame keeps its own valid bit, so a sector frame can be partly filled.

A processor-side port accepts one request at a time. A read that finds its block valid is answered from the cache one cycle after it is accepted. A read whose sector tag matches but whose block is invalid fetches only that one block and keeps the tag. A read whose sector tag matches no frame takes a victim frame, chosen by a round-robin pointer. The victim is given the new tag, all of its block valid bits are cleared, and the one missing block is then fetched. Writes always go through to memory. A write updates the cache only when its block is already valid, and it never allocates a frame.

The memory side is a single request channel. The controller holds the request steady until memory returns an acknowledge. For reads, the fill word arrives together with that acknowledge.

Top module: `sector_cache`

## Requirements
- R1: After reset, req_ready is 1, resp_valid is 0, mem_req_valid is 0, and no block is valid, so the first read of any address is a miss.
- R2: A read whose sector tag matches and whose block valid bit is set is answered with resp_valid=1, resp_hit=1 and the cached word in the cycle after acceptance, and no memory request is made.
- R3: A read miss raises mem_req_valid with mem_req_write=0 and mem_req_addr equal to the request address, and holds it until mem_ack. In the cycle after mem_ack, resp_valid=1, resp_hit=0 and resp_rdata equals mem_rdata, and a later read of that address hits.
- R4: A read whose sector tag matches but whose block is invalid fetches only that block and keeps the sector tag. Other blocks of the sector stay invalid, and blocks that were already valid in the sector keep hitting.
- R5: When no sector tag matches a read, the victim frame is taken in round-robin order 0,1,...,FRAMES-1 and then wraps. With four frames, the fifth distinct sector evicts the first one, and the other three still hit.
- R6: A frame that is reallocated to a new sector has all of its block valid bits cleared. A block index that was valid for the old sector misses for the new one.
- R7: Every write raises mem_req_valid with mem_req_write=1, the request address and the write data, and holds them until mem_ack. resp_valid follows in the next cycle, with resp_hit=1 exactly when the block was valid in the cache.
- R8: A write to a valid block updates the cached word, and a later read hits and returns the written data.
- R9: A write miss allocates nothing and does not advance the round-robin pointer. A later read of that address misses and returns the memory contents.
- R10: req_ready is 0 from the cycle after a miss or write is accepted until the response cycle. It is 1 in every idle cycle, including the cycle that returns a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address, {sector tag, block index} |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Controller can accept a request |
| resp_valid | output | 1 | Response present for one cycle |
| resp_hit | output | 1 | Block was valid in the cache |
| resp_rdata | output | DATA_W | Read data (write data for writes) |
| mem_req_valid | output | 1 | Memory request outstanding |
| mem_req_write | output | 1 | Memory request is a write |
| mem_req_addr | output | ADDR_W | Memory block address |
| mem_req_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory completes the request this cycle |
| mem_rdata | input | DATA_W | Fill data, valid with mem_ack on reads |

## Verification
A block hit is due exactly one cycle after the accepting edge. A miss or write shows its memory request in that same cycle, and its response comes one cycle after the edge that samples mem_ack. The bench drives inputs on falling edges and samples at the next falling edge after each of those registers. A behavioural model of tags, valid bits, round-robin pointer and memory decides beforehand whether each access is a hit. On every cycle of a transaction the bench checks that no response has appeared early and that the memory request is held. Memory latency varies with the address, so the hold and acknowledge path is exercised for several lengths.

// File: rtl/sector_cache_pkg.sv
package sector_cache_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_WRITE = 2'd2
    } ctrl_state_e;
endpackage

// File: rtl/sc_tag_match.sv
module sc_tag_match #(
    parameter int FRAMES  = 4,
    parameter int TAG_W   = 10,
    parameter int FRAME_W = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TAG_W-1:0]   lookup_tag,
    input  logic               tag_we,
    input  logic [FRAME_W-1:0] tag_frame,
    input  logic [TAG_W-1:0]   tag_new,
    output logic               sector_hit,
    output logic [FRAME_W-1:0] hit_frame
);
    typedef struct packed {
        logic [FRAMES-1:0][TAG_W-1:0] tag;
        logic [FRAMES-1:0]            used;
    } tag_regs_t;

    tag_regs_t r_d, r_q;
    logic [FRAMES-1:0] match;

    // one comparator per sector frame, all in parallel
    for (genvar f = 0; f < FRAMES; f++) begin : g_cmp
        assign match[f] = r_q.used[f] && (r_q.tag[f] == lookup_tag);
    end

    always_comb begin
        hit_frame = '0;
        for (int f = 0; f < FRAMES; f++) begin
            if (match[f]) hit_frame = hit_frame | FRAME_W'(f);
        end
        sector_hit = |match;
    end

    always_comb begin
        r_d = r_q;
        if (tag_we) begin
            r_d.tag[tag_frame]  = tag_new;
            r_d.used[tag_frame] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/sc_victim_rr.sv
module sc_victim_rr #(
    parameter int FRAMES  = 4,
    parameter int FRAME_W = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               advance,
    output logic [FRAME_W-1:0] victim
);
    localparam logic [FRAME_W-1:0] LAST = FRAME_W'(FRAMES - 1);

    logic [FRAME_W-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (advance) ptr_d = (ptr_q == LAST) ? '0 : ptr_q + FRAME_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign victim = ptr_q;
endmodule

// File: rtl/sc_block_store.sv
module sc_block_store #(
    parameter int FRAMES  = 4,
    parameter int BLOCKS  = 4,
    parameter int DATA_W  = 32,
    parameter int FRAME_W = (FRAMES > 1) ? $clog2(FRAMES) : 1,
    parameter int BLK_W   = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_en,
    input  logic [FRAME_W-1:0] clear_frame,
    input  logic               wr_en,
    input  logic [FRAME_W-1:0] wr_frame,
    input  logic [BLK_W-1:0]   wr_blk,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [FRAME_W-1:0] rd_frame,
    input  logic [BLK_W-1:0]   rd_blk,
    output logic               rd_valid,
    output logic [DATA_W-1:0]  rd_data
);
    typedef struct packed {
        logic [FRAMES-1:0][BLOCKS-1:0]             valid;
        logic [FRAMES-1:0][BLOCKS-1:0][DATA_W-1:0] data;
    } store_regs_t;

    store_regs_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clear_en) s_d.valid[clear_frame] = '0;
        if (wr_en) begin
            s_d.data[wr_frame][wr_blk]  = wr_data;
            s_d.valid[wr_frame][wr_blk] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_valid = s_q.valid[rd_frame][rd_blk];
    assign rd_data  = s_q.data[rd_frame][rd_blk];
endmodule

// File: rtl/sector_cache.sv
module sector_cache
    import sector_cache_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int FRAMES = 4,
    parameter int BLOCKS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              mem_req_valid,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int FRAME_W = (FRAMES > 1) ? $clog2(FRAMES) : 1;
    localparam int BLK_W   = (BLOCKS > 1) ? $clog2(BLOCKS) : 1;
    localparam int TAG_W   = ADDR_W - BLK_W;

    typedef struct packed {
        ctrl_state_e        state;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  wdata;
        logic [FRAME_W-1:0] frame;
        logic               was_hit;
        logic               resp_valid;
        logic               resp_hit;
        logic [DATA_W-1:0]  resp_rdata;
    } ctrl_regs_t;

    ctrl_regs_t c_d, c_q;

    logic [TAG_W-1:0]   lk_tag;
    logic [BLK_W-1:0]   lk_blk;
    logic               sector_hit;
    logic [FRAME_W-1:0] hit_frame;
    logic               tag_we;
    logic [FRAME_W-1:0] tag_frame;
    logic [FRAME_W-1:0] victim;
    logic               rr_adv;
    logic               clr_en;
    logic               st_wr_en;
    logic [FRAME_W-1:0] st_wr_frame;
    logic [BLK_W-1:0]   st_wr_blk;
    logic [DATA_W-1:0]  st_wr_data;
    logic               blk_valid;
    logic [DATA_W-1:0]  blk_data;
    logic               blk_hit;

    assign lk_tag  = req_addr[ADDR_W-1:BLK_W];
    assign lk_blk  = req_addr[BLK_W-1:0];
    assign blk_hit = sector_hit && blk_valid;

    sc_tag_match #(.FRAMES(FRAMES), .TAG_W(TAG_W), .FRAME_W(FRAME_W)) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .lookup_tag (lk_tag),
        .tag_we     (tag_we),
        .tag_frame  (tag_frame),
        .tag_new    (lk_tag),
        .sector_hit (sector_hit),
        .hit_frame  (hit_frame)
    );

    sc_victim_rr #(.FRAMES(FRAMES), .FRAME_W(FRAME_W)) u_rr (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (rr_adv),
        .victim  (victim)
    );

    sc_block_store #(
        .FRAMES(FRAMES), .BLOCKS(BLOCKS), .DATA_W(DATA_W),
        .FRAME_W(FRAME_W), .BLK_W(BLK_W)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_en    (clr_en),
        .clear_frame (victim),
        .wr_en       (st_wr_en),
        .wr_frame    (st_wr_frame),
        .wr_blk      (st_wr_blk),
        .wr_data     (st_wr_data),
        .rd_frame    (hit_frame),
        .rd_blk      (lk_blk),
        .rd_valid    (blk_valid),
        .rd_data     (blk_data)
    );

    always_comb begin
        c_d          = c_q;
        c_d.resp_valid = 1'b0;
        tag_we       = 1'b0;
        tag_frame    = victim;
        rr_adv       = 1'b0;
        clr_en       = 1'b0;
        st_wr_en     = 1'b0;
        st_wr_frame  = hit_frame;
        st_wr_blk    = lk_blk;
        st_wr_data   = req_wdata;

        unique case (c_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    c_d.addr  = req_addr;
                    c_d.wdata = req_wdata;
                    if (req_write) begin
                        c_d.state   = ST_WRITE;
                        c_d.was_hit = blk_hit;
                        st_wr_en    = blk_hit;
                    end else if (blk_hit) begin
                        c_d.resp_valid = 1'b1;
                        c_d.resp_hit   = 1'b1;
                        c_d.resp_rdata = blk_data;
                    end else begin
                        c_d.state = ST_FILL;
                        if (sector_hit) begin
                            c_d.frame = hit_frame;
                        end else begin
                            c_d.frame = victim;
                            tag_we    = 1'b1;
                            clr_en    = 1'b1;
                            rr_adv    = 1'b1;
                        end
                    end
                end
            end
            ST_FILL: begin
                st_wr_frame = c_q.frame;
                st_wr_blk   = c_q.addr[BLK_W-1:0];
                st_wr_data  = mem_rdata;
                if (mem_ack) begin
                    st_wr_en       = 1'b1;
                    c_d.state      = ST_IDLE;
                    c_d.resp_valid = 1'b1;
                    c_d.resp_hit   = 1'b0;
                    c_d.resp_rdata = mem_rdata;
                end
            end
            ST_WRITE: begin
                if (mem_ack) begin
                    c_d.state      = ST_IDLE;
                    c_d.resp_valid = 1'b1;
                    c_d.resp_hit   = c_q.was_hit;
                    c_d.resp_rdata = c_q.wdata;
                end
            end
            default: c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign req_ready     = (c_q.state == ST_IDLE);
    assign resp_valid    = c_q.resp_valid;
    assign resp_hit      = c_q.resp_hit;
    assign resp_rdata    = c_q.resp_rdata;
    assign mem_req_valid = (c_q.state != ST_IDLE);
    assign mem_req_write = (c_q.state == ST_WRITE);
    assign mem_req_addr  = c_q.addr;
    assign mem_req_wdata = c_q.wdata;
endmodule

// File: rtl/sector_cache_chk.sv
module sector_cache_chk #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              resp_valid,
    input logic              resp_hit,
    input logic              mem_req_valid,
    input logic              mem_req_write,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic [DATA_W-1:0] mem_req_wdata,
    input logic              mem_ack
);
    // R7
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_ack) |=> (mem_req_valid && $stable(mem_req_write)
            && $stable(mem_req_addr) && $stable(mem_req_wdata)));

    // R10
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);

    // R3
    ack_then_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_ack) |=> resp_valid);

    // R3
    fill_is_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_ack && !mem_req_write) |=> !resp_hit);

    // R2
    local_resp_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !$past(mem_req_valid)) |-> resp_hit);

    // R1
    resp_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (req_ready && !mem_req_valid));
endmodule

bind sector_cache sector_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_ready     (req_ready),
    .resp_valid    (resp_valid),
    .resp_hit      (resp_hit),
    .mem_req_valid (mem_req_valid),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_ack       (mem_ack)
);

// File: tb/sector_cache_test.sv
`timescale 1ns/1ps
module sector_cache_test;
    localparam int AW = 12;
    localparam int DW = 32;
    localparam int NF = 4;
    localparam int NB = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, resp_valid, resp_hit;
    logic [DW-1:0] resp_rdata;
    logic          mem_req_valid, mem_req_write;
    logic [AW-1:0] mem_req_addr;
    logic [DW-1:0] mem_req_wdata;
    logic          mem_ack = 1'b0;
    logic [DW-1:0] mem_rdata = '0;

    int total = 0;
    int failed = 0;

    logic [DW-1:0] mem [0:(1<<AW)-1];
    int            m_tag [NF];
    bit            m_used [NF];
    bit            m_val [NF][NB];
    logic [DW-1:0] m_dat [NF][NB];
    int            m_rr = 0;

    always #5 clk = ~clk;

    sector_cache #(.ADDR_W(AW), .DATA_W(DW), .FRAMES(NF), .BLOCKS(NB)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_rdata(resp_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one processor transaction, checked against the model cycle by cycle
    task automatic txn(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                       input string req, input int want_hit);
        int  f = -1;
        int  blk = int'(a[1:0]);
        int  t = int'(a[AW-1:2]);
        int  lat;
        bit  bhit;
        for (int i = 0; i < NF; i++) if (m_used[i] && m_tag[i] == t) f = i;
        bhit = (f >= 0) && m_val[f][blk];
        if (want_hit >= 0) check(bhit == bit'(want_hit), {req, " model"}, 32'(bhit), 32'(want_hit));
        @(negedge clk);
        check(req_ready == 1'b1, "R10 ready idle", 32'(req_ready), 1);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        if (!wr && bhit) begin
            check(resp_valid == 1'b1, req, 32'(resp_valid), 1);
            check(resp_hit == 1'b1, req, 32'(resp_hit), 1);
            check(resp_rdata == m_dat[f][blk], req, resp_rdata, m_dat[f][blk]);
            check(mem_req_valid == 1'b0, req, 32'(mem_req_valid), 0);
            check(req_ready == 1'b1, "R10 ready on hit", 32'(req_ready), 1);
        end else begin
            lat = int'(a % 3);
            check(mem_req_valid == 1'b1, req, 32'(mem_req_valid), 1);
            check(mem_req_write == wr, req, 32'(mem_req_write), 32'(wr));
            check(mem_req_addr == a, req, 32'(mem_req_addr), 32'(a));
            if (wr) check(mem_req_wdata == wd, req, mem_req_wdata, wd);
            check(req_ready == 1'b0, "R10 busy", 32'(req_ready), 0);
            for (int i = 0; i < lat; i++) begin
                check(resp_valid == 1'b0 && mem_req_valid == 1'b1, {req, " hold"},
                      32'({resp_valid, mem_req_valid}), 32'b01);
                @(negedge clk);
            end
            mem_ack = 1'b1;
            mem_rdata = mem[a];
            @(negedge clk);
            mem_ack = 1'b0;
            mem_rdata = '0;
            check(resp_valid == 1'b1, req, 32'(resp_valid), 1);
            check(resp_hit == (wr ? bhit : 1'b0), req, 32'(resp_hit), 32'(wr ? bhit : 1'b0));
            if (wr) check(resp_rdata == wd, req, resp_rdata, wd);
            else    check(resp_rdata == mem[a], req, resp_rdata, mem[a]);
            check(mem_req_valid == 1'b0, req, 32'(mem_req_valid), 0);
        end
        // model update
        if (wr) begin
            mem[a] = wd;
            if (bhit) m_dat[f][blk] = wd;
        end else if (!bhit) begin
            if (f < 0) begin
                f = m_rr;
                m_rr = (m_rr + 1) % NF;
                m_tag[f] = t;
                m_used[f] = 1'b1;
                for (int b = 0; b < NB; b++) m_val[f][b] = 1'b0;
            end
            m_val[f][blk] = 1'b1;
            m_dat[f][blk] = mem[a];
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; failed++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        logic [7:0] lfsr = 8'h5B;
        for (int i = 0; i < (1 << AW); i++) mem[i] = (32'(i) * 32'h9E3779B1) ^ 32'h5A5A0000;
        for (int i = 0; i < NF; i++) begin
            m_used[i] = 1'b0; m_tag[i] = 0;
            for (int b = 0; b < NB; b++) begin m_val[i][b] = 1'b0; m_dat[i][b] = '0; end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1, "R1 ready", 32'(req_ready), 1);
        check(resp_valid == 1'b0, "R1 resp", 32'(resp_valid), 0);
        check(mem_req_valid == 1'b0, "R1 mem", 32'(mem_req_valid), 0);

        txn(0, 12'h010, 0, "R1 first read misses", 0);
        txn(0, 12'h010, 0, "R2 read hit", 1);
        txn(0, 12'h011, 0, "R4 block miss in sector", 0);
        txn(0, 12'h010, 0, "R4 tag kept", 1);
        txn(0, 12'h012, 0, "R4 neighbour still invalid", 0);
        txn(0, 12'h013, 0, "R3 fill", 0);
        txn(0, 12'h013, 0, "R3 later hit", 1);
        txn(0, 12'h014, 0, "R5 alloc frame1", 0);
        txn(0, 12'h018, 0, "R5 alloc frame2", 0);
        txn(0, 12'h01C, 0, "R5 alloc frame3", 0);
        txn(0, 12'h020, 0, "R5 wrap evicts frame0", 0);
        txn(0, 12'h010, 0, "R5 evicted sector misses", 0);
        txn(0, 12'h018, 0, "R5 other sector hits", 1);
        txn(0, 12'h011, 0, "R6 cleared on realloc", 0);
        txn(1, 12'h018, 32'hCAFE0018, "R7 write hit", 1);
        txn(0, 12'h018, 0, "R8 read after write", 1);
        txn(1, 12'h300, 32'hBEEF0300, "R7 write miss", 0);
        txn(0, 12'h300, 0, "R9 no allocate", 0);
        txn(0, 12'h01C, 0, "R9 pointer not advanced", 1);
        txn(1, 12'h01D, 32'h0000D01D, "R9 write block miss", 0);
        txn(0, 12'h01D, 0, "R9 block not filled by write", 0);

        for (int n = 0; n < 80; n++) begin
            logic [AW-1:0] a;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            a = {8'h00, 2'b01, lfsr[1:0]} + {5'd0, 3'(lfsr[4:2] % 6), 4'd0} + 12'(lfsr[6:5]);
            txn(lfsr[7] & lfsr[0], a, {24'hA5A5A5, lfsr}, "R2 R3 R5 R7 mixed", -1);
        end

        @(negedge clk);
        check(resp_valid == 1'b0, "R1 idle end", 32'(resp_valid), 0);
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule